// File: doc/BRIEF.md
# Data Cache Tag Maintenance Engine

This block carries out software-issued maintenance commands on the tag array of a small two-way set-associative data cache. Each line holds a tag, a valid bit, a dirty bit and a tag parity bit. Each set also holds one replacement bit, which names the way that takes the next allocation. A command is a 5-bit operation code plus a line address. The operation either looks the address up in the tags, acts on a line chosen directly by raw index bits, or moves a whole tag between a line and a software-visible staging register.

When a command needs a dirty line sent to memory, the engine presents the line address on a valid/ready request port. It completes the tag update only after that request is taken. Commands are taken on a valid/ready port. The ready output is low while a command is in progress, so a caller holding valid simply waits. The writeback port respects back-pressure: the request stays up, with its address held, until memory raises ready. Commands that target other caches are accepted and completed with no effect.

The line address has the set index in bits [IDX_W-1:0] and the tag in the bits above it. Index-type commands use bit IDX_W, the lowest tag bit, as the way select. The staging register and every stored line use the same layout: tag in bits [TAG_W-1:0], valid at bit TAG_W, dirty at bit TAG_W+1, parity at bit TAG_W+2.

Top module: `cme_engine`

## Requirements
- R1: Opcode bits [1:0] select the target cache, and only the value 1 (primary data) acts. Commands for targets 0, 2 and 3 complete with no change, as does operation 7 (set-virtual) on the data cache.
- R2: cmd_ready is high exactly when busy is low. An accepted command raises busy on the next cycle. A command without writeback keeps busy high for one cycle. done pulses for one cycle in the first cycle after busy falls.
- R3: A writeback request holds wb_valid with a stable wb_addr until wb_ready. wb_addr is {line tag, set index}. A request is made only for a line that is valid and dirty.
- R4: Operation 2 (index store tag) writes the staging tag, valid and dirty fields into the indexed line and way. It recomputes parity as the XOR of the tag bits and resets that set's replacement bit to way 0.
- R5: Operation 1 (index load tag) copies the indexed line's tag, valid, dirty and parity fields into the staging register.
- R6: Hit operations (4, 5, 6) match the address tag against valid lines of the set. On a miss they change nothing and request no writeback.
- R7: Operation 4 (hit invalidate) clears valid and dirty without a writeback, even on a dirty line.
- R8: Operation 6 (hit writeback) writes back a dirty line, then clears dirty and keeps the line valid. On a clean line it does nothing.
- R9: Operation 5 (hit writeback-invalidate) and operation 0 (index writeback-invalidate) write back the line if it is dirty and valid, then clear valid and dirty.
- R10: Operation 3 (create dirty exclusive) sets dirty on a hit. On a miss it takes the way named by the replacement bit, writing it back first if it is dirty. It installs the address tag as valid and dirty and points the replacement bit at the other way.
- R11: A software write to the staging register takes effect when idle and is ignored while busy.
- R12: After reset every line and replacement bit is zero, the staging register reads zero, and busy, done and wb_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 5 | Operation [4:2], target [1:0] |
| cmd_addr | input | TAG_W+IDX_W | Line address {tag, index} |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Memory takes the writeback |
| wb_addr | output | TAG_W+IDX_W | Line address to write back |
| taglo_we | input | 1 | Staging register write strobe |
| taglo_wdata | input | TAG_W+3 | Staging register write data |
| taglo_rdata | output | TAG_W+3 | Staging register contents |

## Verification
The bench builds the engine with a 6-bit tag and a 2-bit index, giving four sets. This is small enough that every set, both ways and the replacement bit's toggling can be driven and read back through index load tag. Tags with odd and even bit counts exercise parity recomputation. Writeback replies with zero and several cycles of delay cover back-pressure and a software staging write that lands during a held request.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [2:0] {
    FN_IDX_WBINV = 3'd0,
    FN_IDX_LDTAG = 3'd1,
    FN_IDX_STTAG = 3'd2,
    FN_CDE       = 3'd3,
    FN_HIT_INV   = 3'd4,
    FN_HIT_WBINV = 3'd5,
    FN_HIT_WB    = 3'd6,
    FN_HIT_SETV  = 3'd7
  } cme_fn_e;

  localparam logic [1:0] TGT_PDATA = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WB} cme_state_e;
endpackage

// File: rtl/cme_tag_array.sv
module cme_tag_array #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W+2:0] rd_line0,
  output logic [TAG_W+2:0] rd_line1,
  output logic             rd_lru,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic             lru_we,
  input  logic             lru_val
);
  localparam int SETS = 1 << IDX_W;
  localparam int LW   = TAG_W + 3;

  logic [LW-1:0]   line0_q [SETS];
  logic [LW-1:0]   line1_q [SETS];
  logic [SETS-1:0] lru_q;
  logic [LW-1:0]   wr_line;

  // parity bit keeps the tag field at even total weight
  assign wr_line = {^wr_tag, wr_dirty, wr_valid, wr_tag};

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line0_q[s] <= '0;
        line1_q[s] <= '0;
        lru_q[s]   <= 1'b0;
      end else begin
        if (wr_en && wr_idx == IDX_W'(s) && !wr_way) line0_q[s] <= wr_line;
        if (wr_en && wr_idx == IDX_W'(s) &&  wr_way) line1_q[s] <= wr_line;
        if (lru_we && wr_idx == IDX_W'(s))           lru_q[s]   <= lru_val;
      end
    end
  end

  assign rd_line0 = line0_q[rd_idx];
  assign rd_line1 = line1_q[rd_idx];
  assign rd_lru   = lru_q[rd_idx];
endmodule

// File: rtl/cme_lookup.sv
module cme_lookup #(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W:0]   way0,
  input  logic [TAG_W:0]   way1,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic             hit_way
);
  logic m0, m1;
  assign m0      = way0[TAG_W] && (way0[TAG_W-1:0] == tag);
  assign m1      = way1[TAG_W] && (way1[TAG_W-1:0] == tag);
  assign hit     = m0 || m1;
  assign hit_way = !m0;
endmodule

// File: rtl/cme_ctrl.sv
module cme_ctrl
  import cme_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [4:0]             cmd_op,
  input  logic [TAG_W+IDX_W-1:0] cmd_addr,
  output logic                   cmd_ready,
  output logic                   busy,
  output logic                   done,
  output logic                   wb_valid,
  input  logic                   wb_ready,
  output logic [TAG_W+IDX_W-1:0] wb_addr,
  output logic [IDX_W-1:0]       idx,
  output logic [TAG_W-1:0]       atag,
  input  logic [TAG_W+2:0]       line0,
  input  logic [TAG_W+2:0]       line1,
  input  logic                   lru,
  input  logic                   hit,
  input  logic                   hit_way,
  input  logic [TAG_W+1:0]       stage,
  output logic                   wr_en,
  output logic                   wr_way,
  output logic [TAG_W-1:0]       wr_tag,
  output logic                   wr_valid,
  output logic                   wr_dirty,
  output logic                   lru_we,
  output logic                   lru_val,
  output logic                   tl_load,
  output logic [TAG_W+2:0]       tl_data
);
  localparam int AW = TAG_W + IDX_W;

  cme_state_e    state_q;
  logic [4:0]    op_q;
  logic [AW-1:0] addr_q;
  cme_fn_e       fn;
  logic          mine, hit_kind, act, wb_kind, need_wb, commit;
  logic [TAG_W+2:0] line;
  logic [TAG_W-1:0] ltag;
  logic          lv, ld;

  assign fn       = cme_fn_e'(op_q[4:2]);
  assign mine     = (op_q[1:0] == TGT_PDATA);
  assign idx      = addr_q[IDX_W-1:0];
  assign atag     = addr_q[AW-1:IDX_W];
  assign hit_kind = (fn == FN_HIT_INV) || (fn == FN_HIT_WBINV) || (fn == FN_HIT_WB);

  always_comb begin
    if (fn == FN_IDX_WBINV || fn == FN_IDX_LDTAG || fn == FN_IDX_STTAG) wr_way = addr_q[IDX_W];
    else if (fn == FN_CDE) wr_way = hit ? hit_way : lru;
    else wr_way = hit_way;
  end

  assign line    = wr_way ? line1 : line0;
  assign ltag    = line[TAG_W-1:0];
  assign lv      = line[TAG_W];
  assign ld      = line[TAG_W+1];
  assign act     = mine && (fn != FN_HIT_SETV) && (hit_kind ? hit : 1'b1);
  assign wb_kind = (fn == FN_IDX_WBINV) || (fn == FN_HIT_WBINV) || (fn == FN_HIT_WB)
                   || (fn == FN_CDE && !hit);
  assign need_wb = act && lv && ld && wb_kind;
  assign commit  = (state_q == ST_EXEC && !need_wb) || (state_q == ST_WB && wb_ready);

  assign wr_en   = commit && act && (fn != FN_IDX_LDTAG);
  assign tl_load = commit && act && (fn == FN_IDX_LDTAG);
  assign tl_data = line;
  assign lru_we  = commit && act && (fn == FN_IDX_STTAG || fn == FN_CDE);
  assign lru_val = (fn == FN_CDE) ? !wr_way : 1'b0;

  always_comb begin
    wr_tag   = ltag;
    wr_valid = lv;
    wr_dirty = ld;
    case (fn)
      FN_IDX_WBINV, FN_HIT_INV, FN_HIT_WBINV: begin
        wr_valid = 1'b0;
        wr_dirty = 1'b0;
      end
      FN_IDX_STTAG: begin
        wr_tag   = stage[TAG_W-1:0];
        wr_valid = stage[TAG_W];
        wr_dirty = stage[TAG_W+1];
      end
      FN_CDE: begin
        wr_tag   = atag;
        wr_valid = 1'b1;
        wr_dirty = 1'b1;
      end
      FN_HIT_WB: wr_dirty = 1'b0;
      default: ;
    endcase
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign wb_valid  = (state_q == ST_WB);
  assign wb_addr   = {ltag, idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          addr_q  <= cmd_addr;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= need_wb ? ST_WB : ST_IDLE;
          done    <= !need_wb;
        end
        ST_WB: if (wb_ready) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cme_engine.sv
module cme_engine #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [4:0]             cmd_op,
  input  logic [TAG_W+IDX_W-1:0] cmd_addr,
  output logic                   busy,
  output logic                   done,
  output logic                   wb_valid,
  input  logic                   wb_ready,
  output logic [TAG_W+IDX_W-1:0] wb_addr,
  input  logic                   taglo_we,
  input  logic [TAG_W+2:0]       taglo_wdata,
  output logic [TAG_W+2:0]       taglo_rdata
);
  localparam int LW = TAG_W + 3;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] atag, wr_tag;
  logic [LW-1:0]    line0, line1, tl_data, stage_q;
  logic lru, hit, hit_way, wr_en, wr_way, wr_valid, wr_dirty, lru_we, lru_val, tl_load;

  cme_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_line0(line0), .rd_line1(line1),
    .rd_lru(lru), .wr_en(wr_en), .wr_idx(idx), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .lru_we(lru_we), .lru_val(lru_val)
  );

  cme_lookup #(.TAG_W(TAG_W)) u_lookup (
    .way0(line0[TAG_W:0]), .way1(line1[TAG_W:0]), .tag(atag),
    .hit(hit), .hit_way(hit_way)
  );

  cme_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .idx(idx),
    .atag(atag), .line0(line0), .line1(line1), .lru(lru), .hit(hit),
    .hit_way(hit_way), .stage(stage_q[TAG_W+1:0]), .wr_en(wr_en),
    .wr_way(wr_way), .wr_tag(wr_tag), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .lru_we(lru_we), .lru_val(lru_val), .tl_load(tl_load), .tl_data(tl_data)
  );

  // staging register: engine load wins; software writes only when idle
  always_ff @(posedge clk) begin
    if (!rst_n)                 stage_q <= '0;
    else if (tl_load)           stage_q <= tl_data;
    else if (taglo_we && !busy) stage_q <= taglo_wdata;
  end

  assign taglo_rdata = stage_q;
endmodule

// File: rtl/cme_engine_chk.sv
module cme_engine_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          busy,
  input logic          done,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [AW-1:0] wb_addr
);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r3_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  a_r3_wb_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);
endmodule

bind cme_engine cme_engine_chk #(.AW(TAG_W + IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr)
);

// File: tb/cme_engine_bench.sv
module cme_engine_bench;
  localparam int TAG_W = 6;
  localparam int IDX_W = 2;
  localparam int AW = TAG_W + IDX_W;
  localparam int LW = TAG_W + 3;
  localparam logic [4:0] OP_IWBI = 5'b00001, OP_LD = 5'b00101, OP_ST = 5'b01001,
    OP_CDE = 5'b01101, OP_HINV = 5'b10001, OP_HWBI = 5'b10101, OP_HWB = 5'b11001,
    OP_HSV = 5'b11101, OP_ICACHE = 5'b00000;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready, busy, done, wb_valid, wb_ready = 0, taglo_we = 0;
  logic [4:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0, wb_addr;
  logic [LW-1:0] taglo_wdata = '0, taglo_rdata;
  int total = 0, bad = 0, wb_delay = 0, wb_cnt = 0;
  logic [AW-1:0] exp_q[$];

  always #5 clk = ~clk;

  cme_engine #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_cme_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .taglo_we(taglo_we), .taglo_wdata(taglo_wdata), .taglo_rdata(taglo_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  // writeback responder and scoreboard monitor
  always @(negedge clk) begin
    if (wb_ready) wb_ready = 1'b0;
    else if (wb_valid) begin
      if (wb_cnt >= wb_delay) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected writeback", int'(wb_addr), 0);
        else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          chk(wb_addr == e, "R3 writeback address", int'(wb_addr), int'(e));
        end
        wb_ready = 1'b1;
        wb_cnt = 0;
      end else wb_cnt++;
    end
  end

  task automatic send(input logic [4:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk(busy && !cmd_ready, "R2 busy after accept", int'(busy), 1);
  endtask

  task automatic finish_cmd(input int exp_busy);
    int nb = 1;
    forever begin
      @(negedge clk);
      if (!busy) break;
      nb++;
    end
    chk(done, "R2 done after busy", int'(done), 1);
    if (exp_busy > 0) chk(nb == exp_busy, "R2 busy length", nb, exp_busy);
    @(negedge clk);
    chk(!done, "R2 done single pulse", int'(done), 0);
    chk(exp_q.size() == 0, "R3 expected writeback missing", exp_q.size(), 0);
  endtask

  task automatic run(input logic [4:0] op, input logic [AW-1:0] a, input int exp_busy);
    send(op, a);
    finish_cmd(exp_busy);
  endtask

  task automatic tl_write(input logic [LW-1:0] d);
    @(negedge clk);
    taglo_we = 1; taglo_wdata = d;
    @(negedge clk);
    taglo_we = 0;
  endtask

  task automatic rd_line(input logic [IDX_W-1:0] i, input logic w, input logic [LW-1:0] e,
                         input string req);
    run(OP_LD, {{(TAG_W-1){1'b0}}, w, i}, 1);
    chk(taglo_rdata == e, req, int'(taglo_rdata), int'(e));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && cmd_ready && !done && !wb_valid, "R12 idle after reset", int'(busy), 0);
    chk(taglo_rdata == '0, "R12 staging zero", int'(taglo_rdata), 0);
    rd_line(2, 1, 9'h000, "R12 line cleared");
    // R11 idle write, R4 store with parity recompute, R5 load
    tl_write(9'h0EC);
    chk(taglo_rdata == 9'h0EC, "R11 idle staging write", int'(taglo_rdata), 'h0EC);
    run(OP_ST, mk(6'b000001, 1), 1);
    tl_write(9'h000);
    rd_line(1, 1, 9'h1EC, "R4 R5 stored line with parity");
    // R8 hit writeback dirty, then clean
    wb_delay = 3; exp_q.push_back(8'hB1);
    run(OP_HWB, mk(6'b101100, 1), 0);
    rd_line(1, 1, 9'h16C, "R8 dirty cleared valid kept");
    run(OP_HWB, mk(6'b101100, 1), 1);
    // R6 miss
    run(OP_HINV, mk(6'b101101, 1), 1);
    rd_line(1, 1, 9'h16C, "R6 miss no change");
    // R1 other target and set-virtual ignored
    run(OP_ICACHE, mk(6'b000001, 1), 1);
    run(OP_HSV, mk(6'b101100, 1), 1);
    rd_line(1, 1, 9'h16C, "R1 ignored commands");
    // R10 create dirty exclusive: allocation by replacement bit
    run(OP_CDE, mk(6'b010011, 2), 1);
    rd_line(2, 0, 9'h1D3, "R10 install way0");
    run(OP_CDE, mk(6'b100010, 2), 1);
    rd_line(2, 1, 9'h0E2, "R10 install way1");
    wb_delay = 0; exp_q.push_back(8'h4E);
    run(OP_CDE, mk(6'b000111, 2), 0);
    rd_line(2, 0, 9'h1C7, "R10 victim replaced");
    // R7 hit invalidate on dirty line
    run(OP_HINV, mk(6'b100010, 2), 1);
    rd_line(2, 1, 9'h022, "R7 invalidated no writeback");
    // R9 hit writeback-invalidate
    exp_q.push_back(8'h1E);
    run(OP_HWBI, mk(6'b000111, 2), 0);
    rd_line(2, 0, 9'h107, "R9 hit wb-invalidate");
    // R9 index writeback-invalidate clean and dirty
    run(OP_IWBI, mk(6'b000001, 1), 1);
    rd_line(1, 1, 9'h12C, "R9 index invalidate clean");
    tl_write(9'h0C3);
    run(OP_ST, mk(6'b000000, 3), 1);
    exp_q.push_back(8'h0F);
    run(OP_IWBI, mk(6'b000000, 3), 0);
    rd_line(3, 0, 9'h003, "R9 index wb-invalidate dirty");
    // R4 store tag resets replacement bit
    tl_write(9'h000);
    run(OP_ST, mk(6'b000001, 2), 1);
    run(OP_CDE, mk(6'b111000, 2), 1);
    rd_line(2, 0, 9'h1F8, "R4 replacement reset to way0");
    rd_line(2, 1, 9'h000, "R4 way1 untouched");
    // R11 staging write while busy ignored
    tl_write(9'h0C4);
    run(OP_ST, mk(6'b000000, 0), 1);
    wb_delay = 5; exp_q.push_back(8'h10);
    send(OP_HWB, mk(6'b000100, 0));
    tl_write(9'h015);
    finish_cmd(0);
    chk(taglo_rdata == 9'h0C4, "R11 busy write ignored", int'(taglo_rdata), 'h0C4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule